// File: doc/BRIEF.md
# DMA Request Arbiter with Bus-Hold Handshake

This block decides which of four peripheral DMA request lines is served and gains the system bus for it. Each request line is asynchronous to the controller clock. Each line passes through a two-stage synchronizer. It is then qualified by a per-channel mask that the CPU writes. A qualified request raises a hold request toward the CPU. The block waits for hold acknowledge before it becomes bus master.

Once acknowledge is seen, the block captures the winner of a fixed-priority choice and enters its active (master) cycle. During that cycle it drives the acknowledge of the chosen channel, raises address enable and turns on the output driver of the bidirectional I/O-read strobe. Outside the active cycle the strobe is left tristated, so the CPU can use it to read control registers. Service ends when an external agent pulls the active-low end-of-process input low. After one cleanup cycle the block returns to idle and arbitrates again.

Top module: `dma_hold_arbiter`

## Requirements
- R1: A request input that rises before a rising clock edge is reflected in `hold_req` after the third rising edge counted from that one, and not after the second (two synchronizer flops plus the state register).
- R2: Bit i of the mask register blocks channel i when it is 1. The register resets to all ones and is loaded from `mask_wdata` on any cycle with `mask_wr` high. A request only counts as valid when its mask bit is 0, and with no valid request `hold_req` stays low.
- R3: `hold_req` stays high while the block waits for acknowledge. No `chan_ack` bit and no `addr_en` is driven until `hold_ack` has been sampled high at a rising edge.
- R4: Channel 0 has the highest priority and channel 3 the lowest. The chosen channel i is shown as the single bit i of `chan_ack`.
- R5: The channel is captured at the edge where `hold_ack` is sampled high. It does not change until service ends, even when a higher-priority request arrives.
- R6: When `eop_n` is sampled low during the active cycle, `hold_req`, `addr_en`, `ior_oe` and `chan_ack` are all low after that edge. One cycle later the block is idle again.
- R7: Setting the mask bit of the channel in service leaves that service running. After service ends, the masked channel raises no new hold request.
- R8: `addr_en` and `ior_oe` are high exactly during the active cycle, which is the same set of cycles in which `chan_ack` is nonzero.
- R9: While `rst_n` is low and directly after reset, `hold_req`, `chan_ack`, `addr_en` and `ior_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_async | input | 4 | Asynchronous per-channel DMA request lines |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 4 | New mask value; a 1 blocks the channel |
| hold_ack | input | 1 | Bus grant from the CPU |
| eop_n | input | 1 | Active-low external end of service |
| hold_req | output | 1 | Bus request to the CPU |
| chan_ack | output | 4 | One-hot acknowledge of the channel in service |
| addr_en | output | 1 | Enables the upper address latch onto the bus |
| ior_oe | output | 1 | Output enable of the I/O-read strobe driver |

## Verification
The bench goes after priority resolution when several requests are raised at once and the higher channels are masked. An inverted priority chain, or a mask decoded the wrong way, would acknowledge the wrong bit. It checks that a higher-priority request arriving during service does not move the acknowledge, which a design that arbitrates every cycle would get wrong. It also checks that masking the active channel does not cut service short, which a design that aborts on mask would get wrong. Finally it checks the exact synchronizer latency, that nothing is driven while acknowledge is withheld, and that all outputs drop on the cycle after end-of-process. A missing sync stage, an early grant or a lingering address enable would each show up there.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACT  = 2'd2,
    ST_TERM = 2'd3
  } dma_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q_sync
);
  localparam int LAST = STAGES - 1;

  for (genvar c = 0; c < N; c++) begin : g_chan
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async[c]};
    end
    assign q_sync[c] = chain_q[LAST];
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] valid,
  output logic [N-1:0] winner
);
  logic found;
  always_comb begin
    winner = '0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && !found) begin
        winner[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_hold_fsm.sv
module dma_hold_fsm
  import dma_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_any,
  input  logic [N-1:0] winner,
  input  logic         hold_ack,
  input  logic         eop_n,
  output logic         hold_req,
  output logic         addr_en,
  output logic         ior_oe,
  output logic [N-1:0] chan_ack
);
  dma_state_e st_q, st_d;
  logic [N-1:0] lat_q;
  logic         lat_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (valid_any) st_d = ST_REQ;
      ST_REQ: begin
        if (hold_ack && valid_any) st_d = ST_ACT;
        else if (!valid_any)       st_d = ST_IDLE;
      end
      ST_ACT:  if (!eop_n) st_d = ST_TERM;
      ST_TERM: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign lat_en = (st_q == ST_REQ) && hold_ack && valid_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      lat_q <= '0;
    end else begin
      st_q <= st_d;
      if (lat_en) lat_q <= winner;
    end
  end

  assign hold_req = (st_q == ST_REQ) || (st_q == ST_ACT);
  assign addr_en  = (st_q == ST_ACT);
  assign ior_oe   = (st_q == ST_ACT);
  assign chan_ack = (st_q == ST_ACT) ? lat_q : '0;

  p_grant_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_en) |-> $past(hold_ack));
  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_ack));
  p_chan_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && $past(addr_en)) |-> $stable(chan_ack));
  p_eop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && !eop_n) |=> (!hold_req && !addr_en && chan_ack == '0));
  p_strobe_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_ack != '0) |-> (ior_oe && addr_en && hold_req));
endmodule

// File: rtl/dma_hold_arbiter.sv
module dma_hold_arbiter #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_async,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  input  logic         hold_ack,
  input  logic         eop_n,
  output logic         hold_req,
  output logic [N-1:0] chan_ack,
  output logic         addr_en,
  output logic         ior_oe
);
  logic [N-1:0] req_s;
  logic [N-1:0] mask_q;
  logic [N-1:0] valid;
  logic [N-1:0] winner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  assign valid = req_s & ~mask_q;

  dma_req_sync #(.N(N), .STAGES(STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_async(req_async), .q_sync(req_s)
  );

  dma_prio_pick #(.N(N)) pick_i (
    .valid(valid), .winner(winner)
  );

  dma_hold_fsm #(.N(N)) fsm_i (
    .clk(clk), .rst_n(rst_n), .valid_any(|valid), .winner(winner),
    .hold_ack(hold_ack), .eop_n(eop_n), .hold_req(hold_req),
    .addr_en(addr_en), .ior_oe(ior_oe), .chan_ack(chan_ack)
  );

  p_hold_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> $past(valid != '0));
  p_ack_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_en) |-> ((chan_ack & $past(valid)) == chan_ack));
endmodule

// File: tb/dma_hold_arbiter_tb_top.sv
module dma_hold_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req_async, mask_wdata, chan_ack;
  logic       mask_wr, hold_ack, eop_n, hold_req, addr_en, ior_oe;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_hold_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_async(req_async), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .hold_ack(hold_ack), .eop_n(eop_n),
    .hold_req(hold_req), .chan_ack(chan_ack), .addr_en(addr_en), .ior_oe(ior_oe)
  );

  // {req, mask, expected chan_ack}
  localparam logic [11:0] VEC [9] = '{
    {4'b0001, 4'b0000, 4'b0001},
    {4'b1111, 4'b0000, 4'b0001},
    {4'b1110, 4'b0000, 4'b0010},
    {4'b1100, 4'b0000, 4'b0100},
    {4'b1000, 4'b0000, 4'b1000},
    {4'b1111, 4'b0001, 4'b0010},
    {4'b1111, 4'b0111, 4'b1000},
    {4'b1010, 4'b0010, 4'b1000},
    {4'b0110, 4'b0100, 4'b0010}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mask(input logic [3:0] m);
    mask_wr = 1'b1; mask_wdata = m;
    cyc(1);
    mask_wr = 1'b0;
  endtask

  task automatic finish_service();
    eop_n = 1'b0; req_async = '0;
    cyc(1);
    chk("R6 hold_req after eop", hold_req, 0);
    chk("R6 chan_ack after eop", chan_ack, 0);
    chk("R6 addr_en/ior_oe after eop", {addr_en, ior_oe}, 0);
    eop_n = 1'b1; hold_ack = 1'b0;
    cyc(4);
  endtask

  task automatic serve(input logic [3:0] rq, input logic [3:0] m, input logic [3:0] exp);
    write_mask(m);
    req_async = rq;
    cyc(2);
    chk("R1 no hold after two edges", hold_req, 0);
    cyc(1);
    chk("R1 hold after three edges", hold_req, 1);
    hold_ack = 1'b1;
    cyc(1);
    chk("R4 priority chan_ack", chan_ack, exp);
    chk("R8 addr_en/ior_oe active", {addr_en, ior_oe}, 2'b11);
    finish_service();
  endtask

  initial begin
    rst_n = 1'b0; req_async = '0; mask_wr = 1'b0; mask_wdata = '0;
    hold_ack = 1'b0; eop_n = 1'b1;
    cyc(2);
    chk("R9 outputs in reset", {hold_req, chan_ack, addr_en, ior_oe}, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R9 outputs after reset", {hold_req, chan_ack, addr_en, ior_oe}, 0);

    // R2: mask resets to all ones, so a request is blocked
    req_async = 4'b0001;
    cyc(5);
    chk("R2 reset mask blocks request", hold_req, 0);
    req_async = '0;
    cyc(3);

    for (int k = 0; k < 9; k++) begin
      serve(VEC[k][11:8], VEC[k][7:4], VEC[k][3:0]);
    end

    // R2: everything masked
    write_mask(4'b1111);
    req_async = 4'b1111;
    cyc(6);
    chk("R2 all masked no hold", hold_req, 0);
    req_async = '0;
    cyc(3);

    // R3: acknowledge withheld
    write_mask(4'b0000);
    req_async = 4'b0001;
    cyc(3);
    cyc(5);
    chk("R3 hold_req while waiting", hold_req, 1);
    chk("R3 no chan_ack before hold_ack", chan_ack, 0);
    chk("R3 no addr_en before hold_ack", addr_en, 0);
    hold_ack = 1'b1;
    cyc(1);
    chk("R3 chan_ack after hold_ack", chan_ack, 4'b0001);
    finish_service();

    // R5 and R7: latched channel, mask during service
    req_async = 4'b0100;
    cyc(3);
    hold_ack = 1'b1;
    cyc(1);
    chk("R5 initial channel 2", chan_ack, 4'b0100);
    req_async = 4'b0101;
    cyc(5);
    chk("R5 higher priority does not preempt", chan_ack, 4'b0100);
    write_mask(4'b0100);
    cyc(3);
    chk("R7 mask keeps service", chan_ack, 4'b0100);
    chk("R7 addr_en kept", addr_en, 1);
    req_async = 4'b0100;
    cyc(3);
    eop_n = 1'b0;
    cyc(1);
    chk("R6 drop after eop", {hold_req, addr_en, ior_oe}, 0);
    eop_n = 1'b1; hold_ack = 1'b0;
    cyc(6);
    chk("R7 masked channel no new hold", hold_req, 0);
    req_async = '0;
    cyc(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule